// File: doc/BRIEF.md
# Bus Master Transfer Cycle Sequencer

This block runs single transfers on a parallel bus whose control is split across separate strobes, acting as the bus master. A requester hands over one transfer through a valid/ready pair: an address, a memory-or-I/O select, a refresh flag, a burst flag, a direction and, for writes, the data. The sequencer then steps the bus through four phases: address only, status, address-latch strobe and command strobe. The nanosecond rules of the bus become clock counts set by parameters. When the command phase ends, the sequencer returns a one-cycle completion pulse with the captured read data and two flags: one for an error and one for an abort.

The slave can stretch a transfer by pulling the ready line low. The sequencer passes ready through a two-flop synchronizer before using it. A transfer that saw ready low from the latch-strobe phase onward is held to a longer minimum command length. A counter ends the command phase with an error flag if ready stays low too long. The requester can abandon a transfer while it is still in the address or status phase. The status lines then pulse for a programmed width, and neither the latch strobe nor the command strobe is ever asserted.

Status release is timed only from the start of the command strobe. It never waits for ready, so status always goes inactive before the command strobe does.

Top module: `bus_cycle_master`

## Requirements
- R1: After synchronous reset, all active-low strobes (status pair, latch strobe, command strobe, burst, refresh) are high, `bus_addr_oe`, `bus_data_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: An accepted request first drives `bus_addr`, `bus_mio` and `bus_refresh_n` (low when refresh was requested) with `bus_addr_oe` high and status inactive for exactly ADDR_SETUP cycles. The status pair then asserts: write gives `bus_s0_n`=0 and `bus_s1_n`=1, read gives `bus_s0_n`=1 and `bus_s1_n`=0. The two status lines are never low together.
- R3: The latch strobe `bus_adl_n` goes low after status has been low for STAT_SETUP cycles and stays low for ADL_WIDTH cycles. `bus_cmd_n` falls on the same clock edge on which `bus_adl_n` rises, and the two are never low together.
- R4: For a write, `bus_wdata` and `bus_dpar` are valid and `bus_data_oe` is high from the start of the latch-strobe phase, before the command strobe falls. Bit i of `bus_dpar` is the XOR of byte i of the data (even parity). For a read, `bus_data_oe` stays 0.
- R5: If the synchronized ready is never seen low, the command strobe stays low for exactly DEF_CMD cycles.
- R6: Ready is sampled through two flops. If the synchronized ready is seen low during the latch-strobe or command phase, the command strobe stays low until the synchronized ready is high again and has lasted at least EXT_CMD cycles. Ready that rises at the falling-edge sample taken in command cycle L gives a command length of max(L+2, EXT_CMD).
- R7: The status pair and the burst line are released together after exactly STAT_HOLD cycles of command strobe, whatever ready does. They are inactive before the command strobe rises. The burst line is low only while status is low, and only when burst was requested.
- R8: `rsp_rdata` holds `bus_rdata` as sampled on the clock edge where the command strobe is released. `rsp_done` is high for exactly one cycle. `req_ready` is low from acceptance until the transfer ends.
- R9: An abort request sampled in the address or status phase sends the sequencer to an abort phase. Status is low for exactly ABORT_CYC cycles of that phase, the latch and command strobes are never asserted, and `rsp_done` is given with `rsp_aborted`=1.
- R10: An abort request during the latch-strobe or command phase has no effect. The transfer completes normally with `rsp_aborted`=0.
- R11: While the synchronized ready is low, the command phase ends after WAIT_LIMIT cycles of command strobe with `rsp_err`=1. A transfer that ends with ready high gives `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_refresh | input | 1 | Refresh transfer flag |
| req_burst | input | 1 | Burst indication for this transfer |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| abort_req | input | 1 | Abandon the current transfer (address/status phase only) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Transfer ended by wait timeout |
| rsp_aborted | output | 1 | Transfer was aborted |
| rsp_rdata | output | DW | Captured read data |
| bus_addr | output | AW | Bus address |
| bus_addr_oe | output | 1 | Address and qualifiers driven valid |
| bus_mio | output | 1 | Memory/I/O select |
| bus_refresh_n | output | 1 | Refresh indication, active low |
| bus_s0_n | output | 1 | Status line 0, active low (write) |
| bus_s1_n | output | 1 | Status line 1, active low (read) |
| bus_adl_n | output | 1 | Address-latch strobe, active low |
| bus_cmd_n | output | 1 | Command strobe, active low |
| bus_burst_n | output | 1 | Burst indication, active low |
| bus_wdata | output | DW | Write data to bus |
| bus_dpar | output | DW/8 | Even parity per data byte |
| bus_data_oe | output | 1 | Write data driven |
| bus_rdata | input | DW | Read data from bus |
| bus_rdy | input | 1 | Slave ready, asynchronous, low extends the cycle |

## Verification
The bench builds the sequencer with two-cycle address, status and latch phases, STAT_HOLD=2, DEF_CMD=4, EXT_CMD=6, ABORT_CYC=3 and WAIT_LIMIT=20. With these values, extensions that end below, at and above the extended minimum are short runs. Ready releases at command cycles 18 and 19 land one on each side of the timeout edge. The short phases also let an abort be placed in the address phase, the status phase and the ignored latch phase within a few cycles of each other.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_STAT = 3'd2,
    ST_ADL  = 3'd3,
    ST_CMD  = 3'd4,
    ST_ABRT = 3'd5
  } bcm_state_e;
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bcm_dpar.sv
module bcm_dpar #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   data,
  output logic [DW/8-1:0] par
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par[b] = ^data[8*b +: 8];
  end
endmodule

// File: rtl/bcm_fsm.sv
module bcm_fsm
  import bcm_pkg::*;
#(
  parameter int CW         = 8,
  parameter int ADDR_SETUP = 2,
  parameter int STAT_SETUP = 2,
  parameter int ADL_WIDTH  = 2,
  parameter int STAT_HOLD  = 2,
  parameter int DEF_CMD    = 4,
  parameter int EXT_CMD    = 6,
  parameter int ABORT_CYC  = 3,
  parameter int WAIT_LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_burst,
  input  logic abort_req,
  input  logic rdy_s,
  output logic req_ready,
  output logic accept,
  output logic finish,
  output logic addr_oe,
  output logic s0_n,
  output logic s1_n,
  output logic adl_n,
  output logic cmd_n,
  output logic burst_n,
  output logic data_oe,
  output logic done,
  output logic err,
  output logic aborted
);
  localparam logic [CW-1:0] L_AS   = CW'(ADDR_SETUP);
  localparam logic [CW-1:0] L_SS   = CW'(STAT_SETUP);
  localparam logic [CW-1:0] L_ADL  = CW'(ADL_WIDTH);
  localparam logic [CW-1:0] L_HOLD = CW'(STAT_HOLD);
  localparam logic [CW-1:0] L_DEF  = CW'(DEF_CMD);
  localparam logic [CW-1:0] L_EXT  = CW'(EXT_CMD);
  localparam logic [CW-1:0] L_AB   = CW'(ABORT_CYC);
  localparam logic [CW-1:0] L_WAIT = CW'(WAIT_LIMIT);

  bcm_state_e      state_q;
  logic [CW-1:0]   ph_cnt_q;
  logic            wr_q;
  logic            brst_q;
  logic            ext_q;
  logic [CW-1:0]   min_len;
  logic            end_ok;
  logic            end_to;

  always_comb begin
    min_len   = ext_q ? L_EXT : L_DEF;
    end_ok    = rdy_s && (ph_cnt_q >= min_len);
    end_to    = !rdy_s && (ph_cnt_q >= L_WAIT);
    req_ready = (state_q == ST_IDLE);
    accept    = (state_q == ST_IDLE) && req_valid;
    finish    = (state_q == ST_CMD) && (end_ok || end_to);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ph_cnt_q <= '0;
      wr_q     <= 1'b0;
      brst_q   <= 1'b0;
      ext_q    <= 1'b0;
      addr_oe  <= 1'b0;
      s0_n     <= 1'b1;
      s1_n     <= 1'b1;
      adl_n    <= 1'b1;
      cmd_n    <= 1'b1;
      burst_n  <= 1'b1;
      data_oe  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q     <= req_write;
            brst_q   <= req_burst;
            ext_q    <= 1'b0;
            err      <= 1'b0;
            aborted  <= 1'b0;
            addr_oe  <= 1'b1;
            ph_cnt_q <= CW'(1);
            state_q  <= ST_ADDR;
          end
        end
        ST_ADDR, ST_STAT: begin
          if (abort_req) begin
            s0_n     <= ~wr_q;
            s1_n     <= wr_q;
            burst_n  <= ~brst_q;
            ph_cnt_q <= CW'(1);
            state_q  <= ST_ABRT;
          end else if (state_q == ST_ADDR && ph_cnt_q == L_AS) begin
            s0_n     <= ~wr_q;
            s1_n     <= wr_q;
            burst_n  <= ~brst_q;
            ph_cnt_q <= CW'(1);
            state_q  <= ST_STAT;
          end else if (state_q == ST_STAT && ph_cnt_q == L_SS) begin
            adl_n    <= 1'b0;
            data_oe  <= wr_q;
            ph_cnt_q <= CW'(1);
            state_q  <= ST_ADL;
          end else begin
            ph_cnt_q <= ph_cnt_q + CW'(1);
          end
        end
        ST_ADL: begin
          if (!rdy_s) ext_q <= 1'b1;
          if (ph_cnt_q == L_ADL) begin
            adl_n    <= 1'b1;
            cmd_n    <= 1'b0;
            ph_cnt_q <= CW'(1);
            state_q  <= ST_CMD;
          end else begin
            ph_cnt_q <= ph_cnt_q + CW'(1);
          end
        end
        ST_CMD: begin
          if (!rdy_s) ext_q <= 1'b1;
          if (ph_cnt_q == L_HOLD) begin
            s0_n    <= 1'b1;
            s1_n    <= 1'b1;
            burst_n <= 1'b1;
          end
          if (end_ok || end_to) begin
            s0_n    <= 1'b1;
            s1_n    <= 1'b1;
            burst_n <= 1'b1;
            cmd_n   <= 1'b1;
            addr_oe <= 1'b0;
            data_oe <= 1'b0;
            done    <= 1'b1;
            err     <= !end_ok;
            state_q <= ST_IDLE;
          end else begin
            ph_cnt_q <= ph_cnt_q + CW'(1);
          end
        end
        ST_ABRT: begin
          if (ph_cnt_q == L_AB) begin
            s0_n    <= 1'b1;
            s1_n    <= 1'b1;
            burst_n <= 1'b1;
            addr_oe <= 1'b0;
            done    <= 1'b1;
            aborted <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ph_cnt_q <= ph_cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master #(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int CW         = 8,
  parameter int SYNC_STG   = 2,
  parameter int ADDR_SETUP = 2,
  parameter int STAT_SETUP = 2,
  parameter int ADL_WIDTH  = 2,
  parameter int STAT_HOLD  = 2,
  parameter int DEF_CMD    = 4,
  parameter int EXT_CMD    = 6,
  parameter int ABORT_CYC  = 3,
  parameter int WAIT_LIMIT = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_mem,
  input  logic            req_refresh,
  input  logic            req_burst,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            abort_req,
  output logic            rsp_done,
  output logic            rsp_err,
  output logic            rsp_aborted,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_addr_oe,
  output logic            bus_mio,
  output logic            bus_refresh_n,
  output logic            bus_s0_n,
  output logic            bus_s1_n,
  output logic            bus_adl_n,
  output logic            bus_cmd_n,
  output logic            bus_burst_n,
  output logic [DW-1:0]   bus_wdata,
  output logic [DW/8-1:0] bus_dpar,
  output logic            bus_data_oe,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rdy
);
  localparam int NB = DW / 8;

  logic          rdy_s;
  logic          accept;
  logic          finish;
  logic [NB-1:0] par_in;
  logic          rfsh_q;

  bcm_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (bus_rdy),
    .q_sync  (rdy_s)
  );

  bcm_dpar #(.DW(DW)) u_dpar (
    .data (req_wdata),
    .par  (par_in)
  );

  bcm_fsm #(
    .CW(CW), .ADDR_SETUP(ADDR_SETUP), .STAT_SETUP(STAT_SETUP),
    .ADL_WIDTH(ADL_WIDTH), .STAT_HOLD(STAT_HOLD), .DEF_CMD(DEF_CMD),
    .EXT_CMD(EXT_CMD), .ABORT_CYC(ABORT_CYC), .WAIT_LIMIT(WAIT_LIMIT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_burst (req_burst),
    .abort_req (abort_req),
    .rdy_s     (rdy_s),
    .req_ready (req_ready),
    .accept    (accept),
    .finish    (finish),
    .addr_oe   (bus_addr_oe),
    .s0_n      (bus_s0_n),
    .s1_n      (bus_s1_n),
    .adl_n     (bus_adl_n),
    .cmd_n     (bus_cmd_n),
    .burst_n   (bus_burst_n),
    .data_oe   (bus_data_oe),
    .done      (rsp_done),
    .err       (rsp_err),
    .aborted   (rsp_aborted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_mio   <= 1'b0;
      rfsh_q    <= 1'b0;
      bus_wdata <= '0;
      bus_dpar  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        bus_addr  <= req_addr;
        bus_mio   <= req_mem;
        rfsh_q    <= req_refresh;
        bus_wdata <= req_wdata;
        bus_dpar  <= par_in;
      end
      if (finish) rsp_rdata <= bus_rdata;
    end
  end

  assign bus_refresh_n = ~(rfsh_q & bus_addr_oe);
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker (
  input logic clk,
  input logic rst,
  input logic bus_addr_oe,
  input logic bus_s0_n,
  input logic bus_s1_n,
  input logic bus_adl_n,
  input logic bus_cmd_n,
  input logic bus_burst_n,
  input logic bus_data_oe,
  input logic rsp_done,
  input logic rsp_aborted
);
  a_r2_status_needs_addr: assert property (@(posedge clk) disable iff (rst)
    (!bus_s0_n || !bus_s1_n) |-> bus_addr_oe);

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!bus_s0_n && !bus_s1_n));

  a_r3_adl_after_status: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_adl_n) |-> (!bus_s0_n || !bus_s1_n));

  a_r3_cmd_on_adl_release: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cmd_n) |-> $rose(bus_adl_n));

  a_r3_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst)
    !(!bus_adl_n && !bus_cmd_n));

  a_r4_wdata_before_cmd: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_cmd_n) && !bus_s0_n) |-> $past(bus_data_oe));

  a_r7_status_off_before_cmd_off: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cmd_n) |-> (bus_s0_n && bus_s1_n && bus_burst_n));

  a_r7_burst_within_status: assert property (@(posedge clk) disable iff (rst)
    !bus_burst_n |-> (!bus_s0_n || !bus_s1_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r9_abort_no_strobes: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_aborted) |-> ($past(bus_adl_n) && $past(bus_cmd_n)));
endmodule

bind bus_cycle_master bcm_checker u_bcm_checker (
  .clk         (clk),
  .rst         (rst),
  .bus_addr_oe (bus_addr_oe),
  .bus_s0_n    (bus_s0_n),
  .bus_s1_n    (bus_s1_n),
  .bus_adl_n   (bus_adl_n),
  .bus_cmd_n   (bus_cmd_n),
  .bus_burst_n (bus_burst_n),
  .bus_data_oe (bus_data_oe),
  .rsp_done    (rsp_done),
  .rsp_aborted (rsp_aborted)
);

// File: tb/bus_cycle_master_tb_top.sv
module bus_cycle_master_tb_top;
  localparam int AW = 24, DW = 32, NB = DW / 8;
  localparam int AS = 2, SS = 2, AD = 2, HOLD = 2;
  localparam int DEF = 4, EXT = 6, ABT = 3, WAITL = 20;

  typedef struct packed {
    logic          wr;
    logic          mio;
    logic          rfsh;
    logic          brst;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic [7:0]    rdylow;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 24'h12_3456, 32'hDEAD_BEEF, 32'h0000_0000, 8'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 24'h00_03F8, 32'h0,         32'hA5A5_5A5A, 8'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 24'hFF_FFFC, 32'h0102_0304, 32'h0,         8'd1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 24'h80_0000, 32'h0,         32'h1357_9BDF, 8'd6},
    '{1'b1, 1'b1, 1'b1, 1'b1, 24'h00_0010, 32'h8000_0001, 32'h0,         8'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 24'h00_0200, 32'h0,         32'hCAFE_F00D, 8'd19},
    '{1'b1, 1'b0, 1'b0, 1'b0, 24'h55_AA55, 32'hFFFF_00FF, 32'h0,         8'd18},
    '{1'b0, 1'b1, 1'b1, 1'b0, 24'h0A_0B0C, 32'h0,         32'h7654_3210, 8'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            req_valid = 0, req_write = 0, req_mem = 0, req_refresh = 0, req_burst = 0;
  logic [AW-1:0]   req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            abort_req = 0;
  logic [DW-1:0]   bus_rdata = '0;
  logic            bus_rdy = 1'b1;
  logic            req_ready, rsp_done, rsp_err, rsp_aborted;
  logic [DW-1:0]   rsp_rdata, bus_wdata;
  logic [AW-1:0]   bus_addr;
  logic            bus_addr_oe, bus_mio, bus_refresh_n, bus_s0_n, bus_s1_n;
  logic            bus_adl_n, bus_cmd_n, bus_burst_n, bus_data_oe;
  logic [NB-1:0]   bus_dpar;

  bus_cycle_master #(
    .AW(AW), .DW(DW), .ADDR_SETUP(AS), .STAT_SETUP(SS), .ADL_WIDTH(AD),
    .STAT_HOLD(HOLD), .DEF_CMD(DEF), .EXT_CMD(EXT), .ABORT_CYC(ABT), .WAIT_LIMIT(WAITL)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .req_refresh(req_refresh),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .abort_req(abort_req), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_aborted(rsp_aborted), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_mio(bus_mio), .bus_refresh_n(bus_refresh_n),
    .bus_s0_n(bus_s0_n), .bus_s1_n(bus_s1_n), .bus_adl_n(bus_adl_n),
    .bus_cmd_n(bus_cmd_n), .bus_burst_n(bus_burst_n), .bus_wdata(bus_wdata),
    .bus_dpar(bus_dpar), .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // transaction observations
  int n_addr, n_stat, n_stat_pre, n_adl, n_cmd, n_stat_cmd, n_burst, n_burst_bad;
  int n_rd_oe, n_busy_ready;
  logic got_err, got_abt;
  logic [DW-1:0] got_rdata;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cmd(input int l);
    if (l == 0) return DEF;
    if (WAITL < l + 2) return WAITL;
    return (l + 2 > EXT) ? l + 2 : EXT;
  endfunction

  function automatic logic [NB-1:0] exp_par(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  // amode: 0 none, 1 in address phase, 2 in status phase, 3 in latch phase
  task automatic run(input vec_t v, input int amode);
    bit seen_addr = 0, seen_stat = 0, seen_adl = 0, seen_cmd = 0, prev_oe = 0;
    n_addr = 0; n_stat = 0; n_stat_pre = 0; n_adl = 0; n_cmd = 0; n_stat_cmd = 0;
    n_burst = 0; n_burst_bad = 0; n_rd_oe = 0; n_busy_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_mem = v.mio; req_refresh = v.rfsh;
    req_burst = v.brst; req_addr = v.addr; req_wdata = v.wdata; bus_rdata = v.rdata;
    forever begin
      @(negedge clk);
      req_valid = 0;
      abort_req = 0;
      if (rsp_done) break;
      if (bus_addr_oe && !seen_addr) begin
        seen_addr = 1;
        chk(bus_addr == v.addr, "R2 address", 64'(bus_addr), 64'(v.addr));
        chk(bus_mio == v.mio, "R2 mio", 64'(bus_mio), 64'(v.mio));
        chk(bus_refresh_n == !v.rfsh, "R2 refresh", 64'(bus_refresh_n), 64'(!v.rfsh));
        if (amode == 1) abort_req = 1;
      end
      if (bus_addr_oe && req_ready) n_busy_ready++;
      if (!bus_s0_n || !bus_s1_n) begin
        if (!seen_stat) begin
          seen_stat = 1;
          chk(bus_s0_n == !v.wr && bus_s1_n == v.wr, "R2 status polarity",
              64'({bus_s0_n, bus_s1_n}), 64'({!v.wr, v.wr}));
          if (amode == 2) abort_req = 1;
        end
        n_stat++;
        if (bus_adl_n && bus_cmd_n && !seen_adl) n_stat_pre++;
        if (!bus_cmd_n) n_stat_cmd++;
      end else if (bus_addr_oe && !seen_stat) n_addr++;
      if (!bus_adl_n) begin
        if (!seen_adl) begin
          seen_adl = 1;
          if (v.rdylow != 0) bus_rdy = 0;
          if (amode == 3) abort_req = 1;
        end
        n_adl++;
      end
      if (!bus_cmd_n) begin
        n_cmd++;
        if (!seen_cmd && v.wr) begin
          chk(prev_oe && bus_data_oe, "R4 data enabled before command", 64'(prev_oe), 64'd1);
          chk(bus_wdata == v.wdata, "R4 write data", 64'(bus_wdata), 64'(v.wdata));
          chk(bus_dpar == exp_par(v.wdata), "R4 data parity", 64'(bus_dpar), 64'(exp_par(v.wdata)));
        end
        seen_cmd = 1;
        if (v.rdylow != 0 && n_cmd == int'(v.rdylow)) bus_rdy = 1;
      end
      if (!bus_burst_n) begin
        n_burst++;
        if (bus_s0_n && bus_s1_n) n_burst_bad++;
      end
      if (!v.wr && bus_data_oe) n_rd_oe++;
      prev_oe = bus_data_oe;
    end
    got_err = rsp_err; got_abt = rsp_aborted; got_rdata = rsp_rdata;
    @(negedge clk);
    chk(!rsp_done, "R8 done single cycle", 64'(rsp_done), 64'd0);
    chk(req_ready, "R8 ready after done", 64'(req_ready), 64'd1);
    bus_rdy = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_s0_n && bus_s1_n && bus_adl_n && bus_cmd_n && bus_burst_n && bus_refresh_n,
        "R1 strobes idle", 64'({bus_s0_n, bus_s1_n, bus_adl_n, bus_cmd_n, bus_burst_n, bus_refresh_n}), 64'h3F);
    chk(!bus_addr_oe && !bus_data_oe && !rsp_done && req_ready, "R1 enables and ready",
        64'({bus_addr_oe, bus_data_oe, rsp_done, req_ready}), 64'h1);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      run(v, 0);
      chk(n_addr == AS, "R2 address-only cycles", 64'(n_addr), 64'(AS));
      chk(n_stat_pre == SS, "R3 status before latch", 64'(n_stat_pre), 64'(SS));
      chk(n_adl == AD, "R3 latch width", 64'(n_adl), 64'(AD));
      chk(n_cmd == exp_cmd(int'(v.rdylow)), (v.rdylow == 0) ? "R5 default command length" :
          "R6 extended command length", 64'(n_cmd), 64'(exp_cmd(int'(v.rdylow))));
      chk(n_stat_cmd == HOLD, "R7 status hold into command", 64'(n_stat_cmd), 64'(HOLD));
      chk(n_burst == (v.brst ? n_stat : 0) && n_burst_bad == 0, "R7 burst follows status",
          64'(n_burst), 64'(v.brst ? n_stat : 0));
      chk(got_err == (v.rdylow != 0 && WAITL < int'(v.rdylow) + 2), "R11 timeout flag",
          64'(got_err), 64'(v.rdylow != 0 && WAITL < int'(v.rdylow) + 2));
      chk(n_busy_ready == 0, "R8 busy not ready", 64'(n_busy_ready), 64'd0);
      chk(!got_abt, "R9 no abort flag", 64'(got_abt), 64'd0);
      if (!v.wr) begin
        chk(got_rdata == v.rdata, "R8 read data", 64'(got_rdata), 64'(v.rdata));
        chk(n_rd_oe == 0, "R4 read keeps data off", 64'(n_rd_oe), 64'd0);
      end
    end

    // R9: abort in the address phase
    run(VEC[4], 1);
    chk(n_stat == ABT, "R9 abort status width (address phase)", 64'(n_stat), 64'(ABT));
    chk(n_adl == 0 && n_cmd == 0, "R9 no strobes on abort", 64'(n_adl + n_cmd), 64'd0);
    chk(got_abt, "R9 aborted flag", 64'(got_abt), 64'd1);
    chk(n_burst == n_stat, "R7 burst released with status on abort", 64'(n_burst), 64'(n_stat));

    // R9: abort in the status phase
    run(VEC[1], 2);
    chk(n_stat == 1 + ABT, "R9 abort status width (status phase)", 64'(n_stat), 64'(1 + ABT));
    chk(n_adl == 0 && n_cmd == 0, "R9 no strobes on late abort", 64'(n_adl + n_cmd), 64'd0);
    chk(got_abt, "R9 aborted flag late", 64'(got_abt), 64'd1);

    // R10: abort during the latch phase is ignored
    run(VEC[0], 3);
    chk(!got_abt, "R10 abort ignored flag", 64'(got_abt), 64'd0);
    chk(n_cmd == DEF && n_adl == AD, "R10 abort ignored cycle", 64'(n_cmd), 64'(DEF));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule